// File: doc/BRIEF.md
# Wired Interrupt Source Gateway

The gateway sits between a bank of wired interrupt lines and a downstream priority arbiter. Each line passes through a synchroniser and is then sensed according to a per-source mode: ignored, detached from its pin, rising or falling edge, or active-high or active-low level. Qualified events set a per-source pending bit. Each source also has an enable bit. The output vector carries every source that is both pending and enabled, gated by a global interrupt enable.

Software reaches the state through a word-addressed register port. Pending and enable bits can be set or cleared as 32-bit arrays, or one at a time by writing a source number. A domain word holds the global enable and a delivery-mode bit, which is passed on to downstream logic. Sources are numbered from 1. Bit position b of array word k stands for source 32k+b, so bit 0 of word 0 exists for no source.

Top module: `irq_gateway`

## Requirements
- R1: After reset every source is inactive, all pending and enable bits are 0, the global enable is 0, `irq_out` is 0 and the domain word reads 0x80000000.
- R2: The configuration word of source i is at offset 0x0004+(i-1)*4, with the mode in bits [2:0]: 0 inactive, 1 detached, 4 rising edge, 5 falling edge, 6 level high, 7 level low. A write of code 2 or 3 stores 0. Bit 10 and all other upper bits read as 0.
- R3: An inactive source ignores its input and ignores writes to its pending and enable bits. One cycle after a source becomes inactive, its pending and enable bits are 0.
- R4: In mode 4 a rising input edge sets pending, and in mode 5 a falling edge does. Pending then stays set after the input returns, until software clears it.
- R5: In modes 6 and 7, pending equals the asserted level (high for 6, low for 7). A set-by-number written while the input is deasserted leaves pending at 0, and a clear has no lasting effect while the level is asserted.
- R6: A detached source ignores its input. Its pending bit changes only through software writes.
- R7: A write to 0x1C00+4k sets pending for each source whose bit is 1, and a write to 0x1D00+4k clears it. A read of 0x1C00+4k returns the pending bits.
- R8: Writing a source number to 0x1CDC or to 0x2000 sets that source's pending bit, and writing it to 0x1DDC clears the bit. A number of 0, or one above the source count, changes nothing.
- R9: A write to 0x1E00+4k sets enables, and a read of that address returns them. A write to 0x1F00+4k clears enables, so all ones disables the whole word. Writing a number to 0x1EDC sets that enable, and writing it to 0x1FDC clears it.
- R10: A read of 0x1D00+4k returns the synchronised raw input levels of that word's sources, whatever their modes.
- R11: In the domain word at offset 0, bit 8 is the global enable that gates `irq_out`. Bit 2 drives `deliver_msi`. Bit 0 reads as 0 and ignores writes, and bit 31 always reads as 1.
- R12: `irq_out[i]` is pending AND enable AND the global enable. An input change driven before clock edge n is visible in pending after edge n+2 and not after edge n+1.
- R13: `bus_rdata` loads at the clock edge where `bus_rd` is sampled high, and it holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Wired interrupt lines; bit i is source i |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| irq_out | output | NUM_SRC | Pending, enabled and globally enabled sources |
| deliver_msi | output | 1 | Delivery-mode bit of the domain word |

## Verification
The bench probes the exact synchroniser latency. A design that skipped a flop would raise `irq_out` one edge early, and one with an extra flop would miss the sample point. The falling-edge mode is driven with a rising transition that must be ignored, and the level modes get a set-by-number while deasserted and a clear while asserted. A design that latched level sources like edge sources would keep stale pending bits or lose the cleared level. An inactive source is hit with set and enable writes, and a detached source is switched to inactive while pending. Leftover state would show in the array readback. Out-of-range source numbers and a long random mix of array and by-number writes, checked against a bench model, expose any wrong bit-to-source mapping or word decode.

// File: rtl/irq_gw_pkg.sv
// Shared types and register offsets for the wired interrupt gateway.
// Assumes a 16-bit byte-offset register port with 32-bit words.
package irq_gw_pkg;

    localparam int unsigned BUS_AW = 16;
    localparam int unsigned BUS_DW = 32;

    // Sense mode codes; software depends on these values.
    typedef enum logic [2:0] {
        SM_OFF    = 3'd0,
        SM_DETACH = 3'd1,
        SM_RISE   = 3'd4,
        SM_FALL   = 3'd5,
        SM_HIGH   = 3'd6,
        SM_LOW    = 3'd7
    } sense_e;

    localparam logic [BUS_AW-1:0] A_DOMAIN   = 16'h0000;
    localparam logic [BUS_AW-1:0] A_CFG_BASE = 16'h0004;
    localparam logic [BUS_AW-1:0] A_SETP_ARR = 16'h1C00;
    localparam logic [BUS_AW-1:0] A_SETP_NUM = 16'h1CDC;
    localparam logic [BUS_AW-1:0] A_CLRP_ARR = 16'h1D00;
    localparam logic [BUS_AW-1:0] A_CLRP_NUM = 16'h1DDC;
    localparam logic [BUS_AW-1:0] A_SETE_ARR = 16'h1E00;
    localparam logic [BUS_AW-1:0] A_SETE_NUM = 16'h1EDC;
    localparam logic [BUS_AW-1:0] A_CLRE_ARR = 16'h1F00;
    localparam logic [BUS_AW-1:0] A_CLRE_NUM = 16'h1FDC;
    localparam logic [BUS_AW-1:0] A_SETP_LE  = 16'h2000;

    // Map a written code onto a legal mode; reserved codes become inactive.
    function automatic sense_e sense_legalize(input logic [2:0] raw);
        case (raw)
            3'd1:    return SM_DETACH;
            3'd4:    return SM_RISE;
            3'd5:    return SM_FALL;
            3'd6:    return SM_HIGH;
            3'd7:    return SM_LOW;
            default: return SM_OFF;
        endcase
    endfunction

    function automatic logic sense_is_edge(input sense_e m);
        return (m == SM_RISE) || (m == SM_FALL);
    endfunction

    function automatic logic sense_inverted(input sense_e m);
        return (m == SM_FALL) || (m == SM_LOW);
    endfunction

endpackage

// File: rtl/irq_gw_sync.sv
// Two-flop synchroniser for the wired inputs plus one history flop for
// edge detection. Assumes the inputs are asynchronous to clk.
module irq_gw_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] prev
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] hist_q;

    // Shift the raw lines through the synchroniser and history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q  <= '0;
            stage_q <= '0;
            hist_q  <= '0;
        end else begin
            meta_q  <= raw;
            stage_q <= meta_q;
            hist_q  <= stage_q;
        end
    end

    assign lvl  = stage_q;
    assign prev = hist_q;

endmodule

// File: rtl/irq_gw_slot.sv
// Per-source state: sense mode, pending and enable bits.
// Assumes lvl/prev are synchronised and set/clear strobes last one cycle.
// A simultaneous set and clear leaves the bit set.
module irq_gw_slot
    import irq_gw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic       prev,
    input  logic       cfg_we,
    input  logic [2:0] cfg_raw,
    input  logic       set_p,
    input  logic       clr_p,
    input  logic       set_e,
    input  logic       clr_e,
    output logic       pend,
    output logic       en,
    output logic [2:0] mode
);

    sense_e mode_q;
    logic   pend_q, en_q;
    logic   rect, rect_prev, hit;
    logic   pend_nx, en_nx;

    // Rectify the level so that 1 always means asserted.
    always_comb begin
        rect      = sense_inverted(mode_q) ? ~lvl  : lvl;
        rect_prev = sense_inverted(mode_q) ? ~prev : prev;
        hit       = sense_is_edge(mode_q) && rect && !rect_prev;
    end

    // Next pending and enable state by mode.
    always_comb begin
        case (mode_q)
            SM_OFF:          pend_nx = 1'b0;
            SM_DETACH:       pend_nx = (pend_q && !clr_p) || set_p;
            SM_RISE, SM_FALL: pend_nx = (pend_q && !clr_p) || set_p || hit;
            default:         pend_nx = rect;
        endcase
        en_nx = (mode_q == SM_OFF) ? 1'b0 : ((en_q && !clr_e) || set_e);
    end

    // Mode register, written from the configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= SM_OFF;
        else if (cfg_we) mode_q <= sense_legalize(cfg_raw);
    end

    // Pending and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            pend_q <= pend_nx;
            en_q   <= en_nx;
        end
    end

    assign pend = pend_q;
    assign en   = en_q;
    assign mode = mode_q;

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SM_OFF) |=> (!pend_q && !en_q)); // R3

    AST_EDGE_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_is_edge(mode_q) && !pend_q && !set_p && !hit) |=> !pend_q); // R4

endmodule

// File: rtl/irq_gw_regs.sv
// Register decoder and readback for the gateway. Writes take effect at
// the strobe edge; reads are registered and appear one cycle later.
module irq_gw_regs
    import irq_gw_pkg::*;
#(
    parameter int unsigned NUM_SRC = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic                 rd,
    input  logic [BUS_AW-1:0]    addr,
    input  logic [BUS_DW-1:0]    wdata,
    input  logic [NUM_SRC:1]     pend,
    input  logic [NUM_SRC:1]     en,
    input  logic [NUM_SRC:1]     lvl,
    input  logic [3*NUM_SRC-1:0] mode_flat,
    output logic [NUM_SRC:1]     cfg_we,
    output logic [2:0]           cfg_raw,
    output logic [NUM_SRC:1]     set_p,
    output logic [NUM_SRC:1]     clr_p,
    output logic [NUM_SRC:1]     set_e,
    output logic [NUM_SRC:1]     clr_e,
    output logic                 dom_ie,
    output logic                 dom_dm,
    output logic [BUS_DW-1:0]    rdata
);

    localparam int unsigned NWORDS = (NUM_SRC + 32) / 32;
    localparam int unsigned SLOTS  = NWORDS * 32;

    logic              num_ok;
    logic [NUM_SRC:1]  num_hit;
    logic              w_setp_num, w_clrp_num, w_sete_num, w_clre_num;
    logic [SLOTS-1:0]  pend_s, en_s, lvl_s;
    logic [BUS_DW-1:0] rd_val;
    logic              ie_q, dm_q;

    // Qualify a written source number and pick the by-number target.
    always_comb begin
        num_ok     = (wdata != '0) && (wdata <= BUS_DW'(NUM_SRC));
        w_setp_num = wr && ((addr == A_SETP_NUM) || (addr == A_SETP_LE));
        w_clrp_num = wr && (addr == A_CLRP_NUM);
        w_sete_num = wr && (addr == A_SETE_NUM);
        w_clre_num = wr && (addr == A_CLRE_NUM);
    end

    assign cfg_raw = wdata[2:0];

    // Per-source strobes from array and by-number writes.
    for (genvar i = 1; i <= NUM_SRC; i++) begin : g_dec
        localparam int unsigned         WI   = i / 32;
        localparam int unsigned         BI   = i % 32;
        localparam logic [BUS_AW-1:0]   WOFS = BUS_AW'(WI * 4);
        localparam logic [BUS_AW-1:0]   COFS = BUS_AW'((i - 1) * 4);
        assign num_hit[i] = num_ok && (wdata == BUS_DW'(i));
        assign cfg_we[i]  = wr && (addr == A_CFG_BASE + COFS);
        assign set_p[i]   = (wr && (addr == A_SETP_ARR + WOFS) && wdata[BI]) || (w_setp_num && num_hit[i]);
        assign clr_p[i]   = (wr && (addr == A_CLRP_ARR + WOFS) && wdata[BI]) || (w_clrp_num && num_hit[i]);
        assign set_e[i]   = (wr && (addr == A_SETE_ARR + WOFS) && wdata[BI]) || (w_sete_num && num_hit[i]);
        assign clr_e[i]   = (wr && (addr == A_CLRE_ARR + WOFS) && wdata[BI]) || (w_clre_num && num_hit[i]);
    end

    // Domain configuration bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
            dm_q <= 1'b0;
        end else if (wr && (addr == A_DOMAIN)) begin
            ie_q <= wdata[8];
            dm_q <= wdata[2];
        end
    end

    assign dom_ie = ie_q;
    assign dom_dm = dm_q;

    // Widen the source vectors to whole words; bit 0 has no source.
    always_comb begin
        pend_s = '0;
        en_s   = '0;
        lvl_s  = '0;
        pend_s[NUM_SRC:1] = pend;
        en_s[NUM_SRC:1]   = en;
        lvl_s[NUM_SRC:1]  = lvl;
    end

    // Read multiplexer.
    always_comb begin
        rd_val = '0;
        if (addr == A_DOMAIN) begin
            rd_val[31] = 1'b1;
            rd_val[8]  = ie_q;
            rd_val[2]  = dm_q;
        end
        for (int k = 0; k < NWORDS; k++) begin
            if (addr == A_SETP_ARR + BUS_AW'(k * 4)) rd_val = pend_s[k*32 +: 32];
            if (addr == A_CLRP_ARR + BUS_AW'(k * 4)) rd_val = lvl_s[k*32 +: 32];
            if (addr == A_SETE_ARR + BUS_AW'(k * 4)) rd_val = en_s[k*32 +: 32];
        end
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (addr == A_CFG_BASE + BUS_AW'((i - 1) * 4))
                rd_val = {29'd0, mode_flat[3*(i-1) +: 3]};
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_val;
    end

    AST_NUM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(num_hit)); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata)); // R13

    AST_DOMAIN_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (addr == A_DOMAIN)) |=> (rdata[31] && !rdata[0])); // R11

endmodule

// File: rtl/irq_gateway.sv
// Wired interrupt source gateway: synchronises the lines, senses them
// per source, and presents pending-and-enabled sources to an arbiter.
// Assumes single-cycle write and read strobes on the register port.
module irq_gateway
    import irq_gw_pkg::*;
#(
    parameter int unsigned NUM_SRC = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC:1]     src_in,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    output logic [NUM_SRC:1]     irq_out,
    output logic                 deliver_msi
);

    logic [NUM_SRC:1]     lvl, prev;
    logic [NUM_SRC:1]     pend, en;
    logic [NUM_SRC:1]     cfg_we, set_p, clr_p, set_e, clr_e;
    logic [2:0]           cfg_raw;
    logic [3*NUM_SRC-1:0] mode_flat;
    logic                 dom_ie, dom_dm;

    irq_gw_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (src_in),
        .lvl  (lvl),
        .prev (prev)
    );

    for (genvar i = 1; i <= NUM_SRC; i++) begin : g_slot
        irq_gw_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl    (lvl[i]),
            .prev   (prev[i]),
            .cfg_we (cfg_we[i]),
            .cfg_raw(cfg_raw),
            .set_p  (set_p[i]),
            .clr_p  (clr_p[i]),
            .set_e  (set_e[i]),
            .clr_e  (clr_e[i]),
            .pend   (pend[i]),
            .en     (en[i]),
            .mode   (mode_flat[3*(i-1) +: 3])
        );
    end

    irq_gw_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pend     (pend),
        .en       (en),
        .lvl      (lvl),
        .mode_flat(mode_flat),
        .cfg_we   (cfg_we),
        .cfg_raw  (cfg_raw),
        .set_p    (set_p),
        .clr_p    (clr_p),
        .set_e    (set_e),
        .clr_e    (clr_e),
        .dom_ie   (dom_ie),
        .dom_dm   (dom_dm),
        .rdata    (bus_rdata)
    );

    // Qualified interrupt vector for the arbiter.
    assign irq_out     = pend & en & {NUM_SRC{dom_ie}};
    assign deliver_msi = dom_dm;

endmodule

// File: tb/test_irq_gateway.sv
module test_irq_gateway;

    localparam int N = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N:1]    src_in = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N:1]    irq_out;
    logic          deliver_msi;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [N:1] mpend, men;

    always #2.5 clk = ~clk;

    irq_gateway #(.NUM_SRC(N)) i_irq_gateway (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .deliver_msi(deliver_msi)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] cfg_addr(input int i);
        return 16'(16'h0004 + (i - 1) * 4);
    endfunction

    // Word k of a source vector, bit b = source 32k+b.
    function automatic logic [31:0] word_of(input logic [N:1] v, input int k);
        logic [63:0] wide;
        wide = '0;
        wide[N:1] = v;
        return wide[k*32 +: 32];
    endfunction

    function automatic logic [N:1] expect_irq(input logic [N:1] p, input logic [N:1] e);
        return p & e;
    endfunction

    // Apply an array write to a model vector.
    function automatic logic [N:1] arr_apply(input logic [N:1] v, input int k, input logic [31:0] d, input bit set);
        logic [N:1] r;
        r = v;
        for (int b = 0; b < 32; b++) begin
            int s;
            s = k * 32 + b;
            if (s >= 1 && s <= N && d[b]) r[s] = set;
        end
        return r;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d, d2;
        void'($urandom(32'd7321));
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk(irq_out == '0, "R1 irq_out after reset", 64'(irq_out), 0);
        rd(16'h0000, d); chk(d == 32'h8000_0000, "R1 domain reset", d, 32'h8000_0000);
        rd(16'h1C00, d); chk(d == 0, "R1 pending reset", d, 0);
        rd(16'h1E04, d); chk(d == 0, "R1 enable reset", d, 0);
        rd(cfg_addr(7), d); chk(d == 0, "R1 mode reset", d, 0);

        // R2 configuration word
        wr(cfg_addr(1), 32'h0000_0406);
        rd(cfg_addr(1), d); chk(d == 6, "R2 bit10 reads 0", d, 6);
        wr(cfg_addr(2), 32'h2);
        rd(cfg_addr(2), d); chk(d == 0, "R2 reserved code", d, 0);
        wr(cfg_addr(40), 32'h5);
        rd(cfg_addr(40), d); chk(d == 5, "R2 last source cfg", d, 5);
        wr(cfg_addr(40), 32'h0);

        // R11 domain word
        wr(16'h0000, 32'h0000_0105);
        rd(16'h0000, d); chk(d == 32'h8000_0104, "R11 domain readback", d, 32'h8000_0104);
        chk(deliver_msi == 1'b1, "R11 deliver_msi", 64'(deliver_msi), 1);
        wr(16'h0000, 32'h0000_0100);
        chk(deliver_msi == 1'b0, "R11 deliver_msi cleared", 64'(deliver_msi), 0);

        // Sources 1..4: rise, fall, high, low
        wr(cfg_addr(1), 32'h4);
        wr(cfg_addr(2), 32'h5);
        wr(cfg_addr(3), 32'h6);
        wr(cfg_addr(4), 32'h7);
        for (int s = 1; s <= 4; s++) wr(16'h1EDC, 32'(s));
        tick(3);
        chk(irq_out[4] == 1'b1, "R5 level low asserted at 0", 64'(irq_out[4]), 1);

        // R12 latency and R4 rising edge
        @(negedge clk); src_in[1] = 1'b1;
        tick(2); chk(irq_out[1] == 1'b0, "R12 not after two edges", 64'(irq_out[1]), 0);
        tick(1); chk(irq_out[1] == 1'b1, "R12 R4 after three edges", 64'(irq_out[1]), 1);
        @(negedge clk); src_in[1] = 1'b0;
        tick(4); chk(irq_out[1] == 1'b1, "R4 rising pending held", 64'(irq_out[1]), 1);
        wr(16'h1DDC, 32'd1);
        chk(irq_out[1] == 1'b0, "R8 clear by number", 64'(irq_out[1]), 0);

        // R4 falling edge
        @(negedge clk); src_in[2] = 1'b1;
        tick(4); chk(irq_out[2] == 1'b0, "R4 falling ignores rise", 64'(irq_out[2]), 0);
        @(negedge clk); src_in[2] = 1'b0;
        tick(3); chk(irq_out[2] == 1'b1, "R4 falling edge sets", 64'(irq_out[2]), 1);

        // R5 level modes
        wr(16'h1CDC, 32'd3);
        rd(16'h1C00, d); chk(d[3] == 1'b0, "R5 set while deasserted", 64'(d[3]), 0);
        @(negedge clk); src_in[3] = 1'b1;
        tick(3); chk(irq_out[3] == 1'b1, "R5 level high tracks", 64'(irq_out[3]), 1);
        wr(16'h1DDC, 32'd3);
        tick(1); chk(irq_out[3] == 1'b1, "R5 clear while asserted", 64'(irq_out[3]), 1);
        @(negedge clk); src_in[3] = 1'b0; src_in[4] = 1'b1;
        tick(3);
        chk(irq_out[3] == 1'b0, "R5 level high drops", 64'(irq_out[3]), 0);
        chk(irq_out[4] == 1'b0, "R5 level low drops", 64'(irq_out[4]), 0);

        // R10 raw level readback
        @(negedge clk); src_in[5] = 1'b1; src_in[33] = 1'b1; src_in[40] = 1'b1;
        tick(3);
        rd(16'h1D00, d); chk(d == word_of(src_in, 0), "R10 raw word0", d, word_of(src_in, 0));
        rd(16'h1D04, d); chk(d == word_of(src_in, 1), "R10 raw word1", d, word_of(src_in, 1));

        // R3 inactive source 5 with input high
        wr(16'h1CDC, 32'd5);
        wr(16'h1EDC, 32'd5);
        wr(16'h1C00, 32'h0000_0020);
        rd(16'h1C00, d); chk(d[5] == 1'b0, "R3 inactive pending ignored", 64'(d[5]), 0);
        rd(16'h1E00, d); chk(d[5] == 1'b0, "R3 inactive enable ignored", 64'(d[5]), 0);

        // R3 source turned inactive while pending
        wr(cfg_addr(6), 32'h1);
        wr(16'h2000, 32'd6);
        wr(16'h1EDC, 32'd6);
        chk(irq_out[6] == 1'b1, "R8 R6 set by alias", 64'(irq_out[6]), 1);
        wr(cfg_addr(6), 32'h0);
        tick(1);
        chk(irq_out[6] == 1'b0, "R3 off clears output", 64'(irq_out[6]), 0);
        wr(cfg_addr(6), 32'h1);
        rd(16'h1C00, d); chk(d[6] == 1'b0, "R3 pending cleared", 64'(d[6]), 0);
        rd(16'h1E00, d); chk(d[6] == 1'b0, "R3 enable cleared", 64'(d[6]), 0);

        // R6 detached source ignores input
        wr(cfg_addr(7), 32'h1);
        @(negedge clk); src_in[7] = 1'b1;
        tick(4);
        rd(16'h1C00, d); chk(d[7] == 1'b0, "R6 detached ignores input", 64'(d[7]), 0);

        // R11 IE gating
        wr(16'h1CDC, 32'd7);
        wr(16'h1EDC, 32'd7);
        chk(irq_out[7] == 1'b1, "R11 IE on", 64'(irq_out[7]), 1);
        wr(16'h0000, 32'h0);
        chk(irq_out == '0, "R11 IE off gates all", 64'(irq_out), 0);
        wr(16'h0000, 32'h100);

        // R13 read data holds
        rd(16'h1E00, d);
        @(negedge clk); bus_addr = 16'h0000;
        tick(3);
        chk(bus_rdata == d, "R13 rdata holds", bus_rdata, d);

        // Random phase: all sources detached, model pending/enable
        for (int s = 1; s <= N; s++) wr(cfg_addr(s), 32'h1);
        wr(16'h1D00, 32'hFFFF_FFFF); wr(16'h1D04, 32'hFFFF_FFFF);
        wr(16'h1F00, 32'hFFFF_FFFF); wr(16'h1F04, 32'hFFFF_FFFF);
        mpend = '0; men = '0;
        rd(16'h1E00, d); rd(16'h1E04, d2);
        chk((d | d2) == 0, "R9 clear-enable all ones", 64'(d | d2), 0);

        // R8 invalid numbers
        wr(16'h1CDC, 32'd0);
        wr(16'h1CDC, 32'd41);
        wr(16'h2000, 32'h8000_0003);
        rd(16'h1C00, d); rd(16'h1C04, d2);
        chk((d | d2) == 0, "R8 invalid numbers ignored", 64'(d | d2), 0);

        for (int it = 0; it < 400; it++) begin
            int op, s, k;
            logic [31:0] rv;
            string tag;
            op = int'($urandom % 8);
            s  = 1 + int'($urandom % N);
            k  = int'($urandom % 2);
            rv = $urandom;
            case (op)
                0: begin wr(16'h1CDC, 32'(s)); mpend[s] = 1'b1; tag = "R8 set by number"; end
                1: begin wr(16'h2000, 32'(s)); mpend[s] = 1'b1; tag = "R8 set by alias"; end
                2: begin wr(16'h1DDC, 32'(s)); mpend[s] = 1'b0; tag = "R8 clear by number"; end
                3: begin wr(16'h1EDC, 32'(s)); men[s] = 1'b1; tag = "R9 enable by number"; end
                4: begin wr(16'h1FDC, 32'(s)); men[s] = 1'b0; tag = "R9 disable by number"; end
                5: begin wr(16'(16'h1C00 + k * 4), rv); mpend = arr_apply(mpend, k, rv, 1'b1); tag = "R7 set array"; end
                6: begin wr(16'(16'h1D00 + k * 4), rv); mpend = arr_apply(mpend, k, rv, 1'b0); tag = "R7 clear array"; end
                default: begin
                    if (rv[0]) begin wr(16'(16'h1E00 + k * 4), rv); men = arr_apply(men, k, rv, 1'b1); tag = "R9 set enable array"; end
                    else begin wr(16'(16'h1F00 + k * 4), rv); men = arr_apply(men, k, rv, 1'b0); tag = "R9 clear enable array"; end
                end
            endcase
            chk(irq_out == expect_irq(mpend, men), tag, 64'(irq_out), 64'(expect_irq(mpend, men)));
            if (it % 50 == 0) begin
                rd(16'(16'h1C00 + k * 4), d);
                chk(d == word_of(mpend, k), "R7 pending readback", d, word_of(mpend, k));
                rd(16'(16'h1E00 + k * 4), d);
                chk(d == word_of(men, k), "R9 enable readback", d, word_of(men, k));
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule